// File: doc/BRIEF.md
# Block cipher chaining sequencer

This block moves 64-bit blocks between a byte-wide host port and an external block cipher engine. The host writes bytes in and reads bytes out, and three request strobes tell it which register the block wants next: the initial vector, the next input byte or the next result byte. The block assembles eight written bytes into a word and starts the engine with a one-cycle start pulse. It waits for the engine's done flag, then offers the eight result bytes for reading. In chaining mode it also applies the XOR with the chaining register and updates that register after each block.

Three bits of an 8-bit command input control the block. Bit 1 enables processing. Bit 3 selects the direction: 1 means encrypt and 0 means decrypt. Bit 7 selects chaining (1) or independent blocks (0). Mode and direction are captured when the block leaves idle, and they hold until the enable bit is cleared. The cipher rounds and the key handling live in the engine, not here.

The byte port follows valid/ready rules. On the write side, `iv_req` or `din_req` acts as ready, and a byte moves on a clock edge where `wr_valid` is high and `a0_sel` is low. On the read side, `dout_req` acts as valid. The byte on `rd_byte` is taken on an edge where `rd_ready` is high and `a0_sel` is low, and it holds for as long as the host stalls. A high `a0_sel` sends the access to another register outside this block.

Top module: `cbc_seq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, all three request strobes and `eng_start` are low.
- R2: On activation with chaining selected (command bit 7 = 1), `iv_req` is raised first. Exactly eight bytes are accepted for the vector, and then `din_req` rises. With chaining off, `din_req` rises directly and no vector is requested.
- R3: Bytes are transferred most significant byte first. At most one request strobe is high at any time.
- R4: A write made while `a0_sel` is high does not enter the block. The next result is the same as if that write had never occurred.
- R5: After the eighth input byte, `eng_start` pulses for exactly one cycle and no request strobe is high until the engine reports done. In chaining encrypt, `eng_din` is the input block XORed with the chaining register; otherwise it is the input block.
- R6: `eng_dec` is high when command bit 3 was 0 at activation. With chaining off, the result is exactly the engine output.
- R7: In chaining encrypt, each engine output becomes the chaining value for the next block.
- R8: In chaining decrypt, the result is the engine output XORed with the chaining register, and the incoming ciphertext block becomes the new chaining value.
- R9: `dout_req` stays high for exactly eight accepted reads, and then `din_req` rises. `rd_byte` holds steady while the host stalls.
- R10: When command bit 1 is low at a clock edge, all request strobes are low after that edge. A later activation in chaining mode requests the vector again.
- R11: Within one activation, the vector is requested only once. Later blocks go straight to `din_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 8 | Command: bit 7 chaining, bit 3 encrypt, bit 1 activate |
| a0_sel | input | 1 | Override: the access goes elsewhere, not to the request register |
| wr_valid | input | 1 | Host write strobe for `wr_byte` |
| wr_byte | input | 8 | Host write data |
| iv_req | output | 1 | Next vector byte wanted |
| din_req | output | 1 | Next input data byte wanted |
| rd_ready | input | 1 | Host takes `rd_byte` this cycle |
| rd_byte | output | 8 | Current result byte |
| dout_req | output | 1 | Result byte available |
| eng_start | output | 1 | One-cycle engine start |
| eng_dec | output | 1 | Engine direction, 1 = decrypt |
| eng_din | output | 64 | Engine input block |
| eng_done | input | 1 | Engine result valid, one cycle |
| eng_dout | input | 64 | Engine result block |

## Verification
A wrong chaining register cannot be seen in the first result of a chained run. It shows at the ports only when the next block's bytes are read, so the tests always run two chained blocks in each direction. A byte counter that is off by one changes which request strobe is high within one byte time. It also rotates the result bytes, so the first compared output byte exposes it. A lost mode latch or a stale IV flag shows up as a wrong strobe one cycle after activation.

// File: rtl/cbc_seq_pkg.sv
package cbc_seq_pkg;
  localparam int CMD_CBC_BIT = 7;
  localparam int CMD_ENC_BIT = 3;
  localparam int CMD_ACT_BIT = 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_IV,
    S_DIN,
    S_START,
    S_WAIT,
    S_DOUT
  } seq_state_t;
endpackage

// File: rtl/cbc_seq_pack.sv
module cbc_seq_pack #(
  parameter int BLK_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BLK_W-1:0]  word_o,
  output logic [BLK_W-1:0]  word_next,
  output logic              last_o
);
  localparam int NBYTES = BLK_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);

  logic [CNT_W-1:0] cnt;

  // new byte enters at the low end, so the first byte ends up most significant
  assign word_next = {word_o[BLK_W-BYTE_W-1:0], byte_in};
  assign last_o    = shift_en && (cnt == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      word_o <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en) begin
      cnt    <= cnt + 1'b1;
      word_o <= word_next;
    end
  end
endmodule

// File: rtl/cbc_seq_unpack.sv
module cbc_seq_unpack #(
  parameter int BLK_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_W-1:0]  word_in,
  input  logic              shift_en,
  output logic [BYTE_W-1:0] byte_o,
  output logic              last_o
);
  localparam int NBYTES = BLK_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);

  logic [BLK_W-1:0] word_q;
  logic [CNT_W-1:0] cnt;

  assign byte_o = word_q[BLK_W-1 -: BYTE_W];
  assign last_o = shift_en && (cnt == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt    <= '0;
    end else if (load) begin
      word_q <= word_in;
      cnt    <= '0;
    end else if (shift_en) begin
      word_q <= {word_q[BLK_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cbc_seq_top.sv
module cbc_seq_top
  import cbc_seq_pkg::*;
#(
  parameter int BLK_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cmd_i,
  input  logic              a0_sel,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              iv_req,
  output logic              din_req,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              dout_req,
  output logic              eng_start,
  output logic              eng_dec,
  output logic [BLK_W-1:0]  eng_din,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_dout
);
  seq_state_t       state;
  logic             mode_cbc, mode_dec;
  logic [BLK_W-1:0] chain;
  logic [BLK_W-1:0] pk_word, pk_next, result_next;
  logic             pk_last, un_last;
  logic             acc_wr, acc_rd, act;

  assign act      = cmd_i[CMD_ACT_BIT];
  assign iv_req   = (state == S_IV);
  assign din_req  = (state == S_DIN);
  assign dout_req = (state == S_DOUT);
  assign eng_start = (state == S_START);
  assign eng_dec   = mode_dec;

  assign acc_wr = wr_valid && !a0_sel && (iv_req || din_req);
  assign acc_rd = rd_ready && !a0_sel && dout_req;

  assign eng_din     = (mode_cbc && !mode_dec) ? (pk_word ^ chain) : pk_word;
  assign result_next = (mode_cbc && mode_dec) ? (eng_dout ^ chain) : eng_dout;

  cbc_seq_pack #(.BLK_W(BLK_W), .BYTE_W(BYTE_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state == S_IDLE),
    .shift_en (acc_wr),
    .byte_in  (wr_byte),
    .word_o   (pk_word),
    .word_next(pk_next),
    .last_o   (pk_last)
  );

  cbc_seq_unpack #(.BLK_W(BLK_W), .BYTE_W(BYTE_W)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     ((state == S_WAIT) && eng_done),
    .word_in  (result_next),
    .shift_en (acc_rd),
    .byte_o   (rd_byte),
    .last_o   (un_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_cbc <= 1'b0;
      mode_dec <= 1'b0;
      chain    <= '0;
    end else if (!act) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: begin
          mode_cbc <= cmd_i[CMD_CBC_BIT];
          mode_dec <= !cmd_i[CMD_ENC_BIT];
          state    <= cmd_i[CMD_CBC_BIT] ? S_IV : S_DIN;
        end
        S_IV: if (pk_last) begin
          chain <= pk_next;
          state <= S_DIN;
        end
        S_DIN:   if (pk_last) state <= S_START;
        S_START: state <= S_WAIT;
        S_WAIT: if (eng_done) begin
          if (mode_cbc) chain <= mode_dec ? pk_word : eng_dout;
          state <= S_DOUT;
        end
        S_DOUT:  if (un_last) state <= S_DIN;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbc_seq_chk.sv
module cbc_seq_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cmd_i,
  input logic              a0_sel,
  input logic              iv_req,
  input logic              din_req,
  input logic              dout_req,
  input logic              rd_ready,
  input logic [BYTE_W-1:0] rd_byte,
  input logic              eng_start
);
  p_req_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iv_req, din_req, dout_req}));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_start_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !(iv_req || din_req || dout_req));

  p_deact_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_i[1] |=> !(iv_req || din_req || dout_req));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_req && !(rd_ready && !a0_sel)) |=> (!dout_req || $stable(rd_byte)));
endmodule

bind cbc_seq_top cbc_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_i    (cmd_i),
  .a0_sel   (a0_sel),
  .iv_req   (iv_req),
  .din_req  (din_req),
  .dout_req (dout_req),
  .rd_ready (rd_ready),
  .rd_byte  (rd_byte),
  .eng_start(eng_start)
);

// File: tb/cbc_seq_top_tb.sv
module cbc_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmd_i = 8'h00;
  logic        a0_sel = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic        iv_req, din_req, dout_req;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_byte;
  logic        eng_start, eng_dec;
  logic [63:0] eng_din;
  logic        eng_done = 1'b0;
  logic [63:0] eng_dout = 64'h0;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;
  logic [7:0] exp_q[$];

  localparam logic [63:0] KEY = 64'hA5C3_1E97_0F5A_6B2D;
  localparam logic [7:0]  ACT = 8'h02, ENC = 8'h08, CBC = 8'h80;

  always #2 clk = ~clk;

  cbc_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .a0_sel(a0_sel),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .iv_req(iv_req), .din_req(din_req),
    .rd_ready(rd_ready), .rd_byte(rd_byte), .dout_req(dout_req),
    .eng_start(eng_start), .eng_dec(eng_dec), .eng_din(eng_din),
    .eng_done(eng_done), .eng_dout(eng_dout)
  );

  function automatic logic [63:0] f_enc(input logic [63:0] x);
    return {x[55:0], x[63:56]} ^ KEY;
  endfunction
  function automatic logic [63:0] f_dec(input logic [63:0] y);
    logic [63:0] t = y ^ KEY;
    return {t[7:0], t[63:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // engine stub: fixed three-cycle latency
  initial begin
    forever begin
      @(negedge clk);
      if (eng_start) begin
        logic [63:0] r;
        r = eng_dec ? f_dec(eng_din) : f_enc(eng_din);
        repeat (3) @(negedge clk);
        eng_dout = r;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  // monitor: stalls every other cycle, pops and compares each read byte
  initial begin
    bit stall = 1'b0;
    forever begin
      @(negedge clk);
      if (dout_req && !stall) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected byte", {56'h0, rd_byte}, 64'h0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_byte == e, "R3/R6/R7/R8 result byte", {56'h0, rd_byte}, {56'h0, e});
        end
        rd_ready = 1'b1;
      end else begin
        rd_ready = 1'b0;
      end
      stall = ~stall;
    end
  end

  task automatic put(input logic [7:0] b);
    while (!(iv_req || din_req)) @(negedge clk);
    wr_valid = 1'b1;
    wr_byte  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic put_word(input logic [63:0] w, input bit junk);
    for (int i = 7; i >= 0; i--) begin
      put(w[i*8 +: 8]);
      if (junk && i == 4) begin
        a0_sel = 1'b1; wr_valid = 1'b1; wr_byte = 8'hEE;   // R4 override write
        @(negedge clk);
        a0_sel = 1'b0; wr_valid = 1'b0;
      end
    end
  endtask

  // driver: queue expected bytes, send block, wait for the monitor to drain
  task automatic run_block(input logic [63:0] din, input logic [63:0] expv, input bit junk);
    for (int i = 7; i >= 0; i--) exp_q.push_back(expv[i*8 +: 8]);
    put_word(din, junk);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(din_req && !dout_req, "R9 din_req after eight reads", {62'h0, din_req, dout_req}, 64'h2);
  endtask

  task automatic activate(input logic [7:0] c);
    cmd_i = 8'h00;
    repeat (2) @(negedge clk);
    chk(!(iv_req || din_req || dout_req), "R10 strobes low after deactivate",
        {61'h0, iv_req, din_req, dout_req}, 64'h0);
    cmd_i = c;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [63:0] iv, p1, p2, c1, c2, a;
    iv = 64'h0123_4567_89AB_CDEF;
    p1 = 64'h4E6F_7720_6973_2074;
    p2 = 64'hDEAD_BEEF_0BAD_F00D;
    a  = 64'h1122_3344_5566_7788;
    repeat (3) @(negedge clk);
    chk(!(iv_req || din_req || dout_req || eng_start), "R1 quiet in reset",
        {60'h0, iv_req, din_req, dout_req, eng_start}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!(iv_req || din_req || dout_req || eng_start), "R1 quiet after reset",
        {60'h0, iv_req, din_req, dout_req, eng_start}, 64'h0);

    // independent blocks, encrypt then decrypt
    activate(ACT | ENC);
    chk(din_req && !iv_req, "R2 no vector without chaining", {62'h0, iv_req, din_req}, 64'h1);
    run_block(a, f_enc(a), 1'b1);
    run_block(p2, f_enc(p2), 1'b0);
    activate(ACT);
    chk(eng_dec == 1'b1, "R6 decrypt direction", {63'h0, eng_dec}, 64'h1);
    run_block(f_enc(a), a, 1'b0);

    // chaining encrypt
    c1 = f_enc(p1 ^ iv);
    c2 = f_enc(p2 ^ c1);
    activate(CBC | ENC | ACT);
    chk(iv_req && !din_req, "R2 vector requested first", {62'h0, iv_req, din_req}, 64'h2);
    put_word(iv, 1'b0);
    chk(din_req && !iv_req, "R2 data after eight vector bytes", {62'h0, iv_req, din_req}, 64'h1);
    run_block(p1, c1, 1'b0);
    chk(!iv_req, "R11 vector only once", {63'h0, iv_req}, 64'h0);
    run_block(p2, c2, 1'b1);

    // chaining decrypt after reactivation
    activate(CBC | ACT);
    chk(iv_req, "R10 vector again after reactivation", {63'h0, iv_req}, 64'h1);
    put_word(iv, 1'b0);
    run_block(c1, p1, 1'b0);
    run_block(c2, p2, 1'b0);

    // deactivate mid-vector and restart cleanly
    activate(CBC | ENC | ACT);
    put(8'h55); put(8'h66);
    activate(CBC | ENC | ACT);
    put_word(iv, 1'b0);
    run_block(p1, c1, 1'b0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule